// File: doc/BRIEF.md
# Merging Write Buffer for a Write-Through Cache

This block sits between a write-through cache and the next memory level. Every processor store that goes into the cache is also handed to this buffer, which holds it in one of a few block-sized entries and sends it to memory later over a valid/ready port. The processor therefore does not wait for memory on a store. Entries leave in the order they were created. The whole block-aligned address, the block's data and a per-byte valid mask go out in one transfer.

A store to a block that already has a pending entry updates that entry instead of taking a new one. The exceptions are the entry currently presented to memory, which is locked, and addresses in the I/O region, which never merge. Before a read miss goes to memory, the processor presents its address on a check port. The buffer then reports one of three results. If nothing is pending for that word, the read may go ahead of the buffered writes. If the newest pending copy of the word is complete, the buffer forwards it. Otherwise the buffer signals that the read must wait until the buffer drains.

Top module: `wbuf_top`

## Requirements
- R1: While reset is held, and directly after it, the buffer is empty: `mem_valid`, `st_full`, `rd_fwd` and `rd_wait` are all 0.
- R2: A store that does not merge takes a new entry. The address of that entry on the memory side is the store address with its low log2(WORDS*BYTES) bits (4 by default) cleared. Word slot s = `st_addr[3:2]` carries the store data in bits s*32+31..s*32, byte lane b of that word sets `mem_be` bit s*4+b when `st_be[b]` is 1, and every other byte is 0 in both data and mask.
- R3: `mem_valid` is 1 whenever at least one entry is pending. The oldest entry is presented, and it is removed on a cycle where both `mem_valid` and `mem_ready` are 1. Entries drain in creation order.
- R4: A store whose block matches a pending entry, where neither is an I/O access and the entry is not the one presented to memory, overwrites only the enabled bytes of that entry and ORs them into its mask. It takes no new entry.
- R5: The entry presented to memory never merges. A store to its block takes a new entry, and its address, data and mask stay unchanged while `mem_ready` is 0.
- R6: An address is an I/O address when `(addr & 16'hF000) == 16'hF000`. An I/O store always takes its own entry, and an I/O entry never absorbs a later store.
- R7: `st_full` is 1 only when `st_valid` is 1, the store has no merge target and all DEPTH (4) entries are occupied. That store is then not taken. A drain in the same cycle does not free a slot for it.
- R8: When `rd_valid` is 1 and no pending entry for the read's block has any valid byte in the read's word, `rd_fwd` and `rd_wait` are 0 and `rd_data` is 0. The read may go ahead of buffered writes.
- R9: When the newest pending entry that holds any byte of the read's word holds all four bytes, `rd_fwd` is 1 and `rd_data` is that word.
- R10: When that newest entry holds only some bytes of the word, `rd_wait` is 1, `rd_fwd` is 0 and `rd_data` is 0. `rd_fwd` and `rd_wait` are never both 1.
- R11: A taken store becomes visible to the read check and the memory side from the next cycle. The read check is combinational on the current contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W (16) | Store byte address, word aligned |
| st_data | input | DATA_W (32) | Store data word |
| st_be | input | DATA_W/8 (4) | Store byte enables, non-zero |
| st_full | output | 1 | Store stalled this cycle |
| rd_valid | input | 1 | Read check request |
| rd_addr | input | ADDR_W (16) | Read byte address, word aligned |
| rd_fwd | output | 1 | Word forwarded from the buffer |
| rd_wait | output | 1 | Read must wait for the buffer to drain |
| rd_data | output | DATA_W (32) | Forwarded word |
| mem_valid | output | 1 | Entry presented to memory |
| mem_ready | input | 1 | Memory accepts the entry |
| mem_addr | output | ADDR_W (16) | Block-aligned address |
| mem_data | output | WORDS*DATA_W (128) | Block data |
| mem_be | output | WORDS*DATA_W/8 (16) | Per-byte valid mask |

## Verification
The embedded properties assume that the processor presents only word-aligned store and read addresses, and that every store request carries at least one enabled byte. They also assume that a stalled store is simply presented again later. The payload-stability property relies on memory being free to hold `mem_ready` low for any number of cycles. The stimulus keeps to these limits. Every address it generates has zero low bits. Byte enables are drawn from 1 to 15. `mem_ready` toggles freely. While the buffer is full, the bench keeps a pending store asserted to exercise the stall.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_CLEAR = 2'd0,
    RD_FWD   = 2'd1,
    RD_WAIT  = 2'd2
  } rd_res_e;
endpackage

// File: rtl/wbuf_ptrs.sv
module wbuf_ptrs #(
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] count_n;

  always_comb begin
    head_n  = head;
    tail_n  = tail;
    count_n = count;
    if (pop)  head_n = (head == LAST) ? '0 : head + 1'b1;
    if (push) tail_n = (tail == LAST) ? '0 : tail + 1'b1;
    if (push && !pop)      count_n = count + 1'b1;
    else if (!push && pop) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_n;
      tail  <= tail_n;
      count <= count_n;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_push_has_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count != CNT_W'(DEPTH));
  assert_pop_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int BLK_W  = 12,
  parameter int WORDS  = 4,
  parameter int BYTES  = 4,
  parameter int SLOT_W = $clog2(WORDS),
  parameter int DW     = BYTES * 8,
  parameter int LANES  = WORDS * BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic               merge,
  input  logic               pop,
  input  logic [BLK_W-1:0]   in_blk,
  input  logic [SLOT_W-1:0]  in_slot,
  input  logic [DW-1:0]      in_data,
  input  logic [BYTES-1:0]   in_be,
  input  logic               in_io,
  input  logic [BLK_W-1:0]   rd_blk,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [BLK_W-1:0]   q_blk,
  output logic [LANES*8-1:0] q_data,
  output logic [LANES-1:0]   q_mask,
  output logic               st_hit,
  output logic               rd_hit,
  output logic               rd_full,
  output logic [DW-1:0]      rd_word
);
  logic               vld_q, vld_n, io_q, io_n;
  logic [BLK_W-1:0]   blk_n;
  logic [LANES-1:0]   mask_n, lane_we;
  logic [LANES*8-1:0] data_n;
  logic               load_en;
  logic [BYTES-1:0]   slot_mask;

  assign load_en = alloc | merge;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_we[l] = (in_slot == SLOT_W'(l / BYTES)) && in_be[l % BYTES];
    vld_n  = vld_q;
    io_n   = io_q;
    blk_n  = q_blk;
    mask_n = q_mask;
    data_n = q_data;
    if (pop) vld_n = 1'b0;
    if (alloc) begin
      vld_n  = 1'b1;
      io_n   = in_io;
      blk_n  = in_blk;
      mask_n = lane_we;
    end else if (merge) begin
      mask_n = q_mask | lane_we;
    end
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l])  data_n[l*8 +: 8] = in_data[(l % BYTES)*8 +: 8];
      else if (alloc)  data_n[l*8 +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      io_q   <= io_n;
      q_blk  <= blk_n;
      q_mask <= mask_n;
      q_data <= data_n;
    end
  end

  assign slot_mask = q_mask[int'(rd_slot)*BYTES +: BYTES];
  assign st_hit    = vld_q && !io_q && (q_blk == in_blk);
  assign rd_hit    = vld_q && (q_blk == rd_blk) && (|slot_mask);
  assign rd_full   = &slot_mask;
  assign rd_word   = q_data[int'(rd_slot)*DW +: DW];

  assert_io_no_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && io_q && !alloc && !pop) |=> $stable(q_mask));
  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc && merge));
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 32,
  parameter int              WORDS   = 4,
  parameter int              DEPTH   = 4,
  parameter logic [ADDR_W-1:0] IO_MASK = 16'hF000,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      st_valid,
  input  logic [ADDR_W-1:0]         st_addr,
  input  logic [DATA_W-1:0]         st_data,
  input  logic [DATA_W/8-1:0]       st_be,
  output logic                      st_full,
  input  logic                      rd_valid,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic                      rd_fwd,
  output logic                      rd_wait,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORDS*DATA_W-1:0]   mem_data,
  output logic [WORDS*DATA_W/8-1:0] mem_be
);
  import wbuf_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int BYTE_W = $clog2(BYTES);
  localparam int SLOT_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + SLOT_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LANES  = WORDS * BYTES;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]   head, tail, yidx;
  logic [CNT_W-1:0]   count;
  logic               st_io, do_merge, do_alloc, do_pop, rd_any;
  logic [DEPTH-1:0]   st_hit, mhit, rd_hit, rd_full;
  logic [BLK_W-1:0]   e_blk  [DEPTH];
  logic [LANES*8-1:0] e_data [DEPTH];
  logic [LANES-1:0]   e_mask [DEPTH];
  logic [DATA_W-1:0]  e_word [DEPTH];
  rd_res_e            rd_res;

  assign st_io     = (st_addr & IO_MASK) == IO_BASE;
  assign mem_valid = (count != '0);
  assign do_pop    = mem_valid && mem_ready;
  assign do_merge  = st_valid && (|mhit);
  assign do_alloc  = st_valid && !(|mhit) && (count != CNT_W'(DEPTH));
  assign st_full   = st_valid && !(|mhit) && (count == CNT_W'(DEPTH));

  wbuf_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(do_alloc), .pop(do_pop),
    .head(head), .tail(tail), .count(count));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign mhit[g] = st_hit[g] && !st_io && (head != PTR_W'(g));
    wbuf_entry #(.BLK_W(BLK_W), .WORDS(WORDS), .BYTES(BYTES), .SLOT_W(SLOT_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(do_alloc && (tail == PTR_W'(g))),
      .merge(do_merge && mhit[g]),
      .pop(do_pop && (head == PTR_W'(g))),
      .in_blk(st_addr[ADDR_W-1:OFF_W]), .in_slot(st_addr[OFF_W-1:BYTE_W]),
      .in_data(st_data), .in_be(st_be), .in_io(st_io),
      .rd_blk(rd_addr[ADDR_W-1:OFF_W]), .rd_slot(rd_addr[OFF_W-1:BYTE_W]),
      .q_blk(e_blk[g]), .q_data(e_data[g]), .q_mask(e_mask[g]),
      .st_hit(st_hit[g]), .rd_hit(rd_hit[g]), .rd_full(rd_full[g]),
      .rd_word(e_word[g]));
  end

  // newest entry holding any byte of the read word, scanned oldest to newest
  always_comb begin
    int i;
    rd_any = 1'b0;
    yidx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      i = int'(head) + k;
      if (i >= DEPTH) i = i - DEPTH;
      if (rd_hit[i]) begin
        rd_any = 1'b1;
        yidx   = PTR_W'(i);
      end
    end
    if (!rd_valid || !rd_any) rd_res = RD_CLEAR;
    else if (rd_full[yidx])   rd_res = RD_FWD;
    else                      rd_res = RD_WAIT;
  end

  assign rd_fwd   = (rd_res == RD_FWD);
  assign rd_wait  = (rd_res == RD_WAIT);
  assign rd_data  = rd_fwd ? e_word[yidx] : '0;
  assign mem_addr = {e_blk[head], {OFF_W{1'b0}}};
  assign mem_data = e_data[head];
  assign mem_be   = e_mask[head];

  assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_data) && $stable(mem_be)));
  assert_one_merge_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mhit));
  assert_rd_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fwd && rd_wait));
  assert_store_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_be != '0) && (st_addr[BYTE_W-1:0] == '0));
  assert_read_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[BYTE_W-1:0] == '0));
endmodule

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
module sim_wbuf_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, rd_valid, mem_ready;
  logic [15:0]  st_addr, rd_addr;
  logic [31:0]  st_data;
  logic [3:0]   st_be;
  logic         st_full, rd_fwd, rd_wait, mem_valid;
  logic [31:0]  rd_data;
  logic [15:0]  mem_addr;
  logic [127:0] mem_data;
  logic [15:0]  mem_be;

  typedef struct {
    logic [11:0]  blk;
    logic [127:0] data;
    logic [15:0]  mask;
    bit           io;
  } ent_t;

  ent_t  q[$];
  int    nvec = 0;
  int    nbad = 0;
  string ptag = "R2";
  string rovr = "";

  always #4 clk = ~clk;

  wbuf_top u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_full(st_full),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_fwd(rd_fwd), .rd_wait(rd_wait),
    .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be));

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, check, then advance the reference
  task automatic apply(bit stv, logic [15:0] sa, logic [31:0] sd, logic [3:0] sbe,
                       bit rdv, logic [15:0] ra, bit rdy);
    bit          sio, efull, efwd, ewait, dopop;
    int          tgt, y, rs, ss;
    logic [31:0] edata;
    string       rtag;
    st_valid = stv; st_addr = sa; st_data = sd; st_be = sbe;
    rd_valid = rdv; rd_addr = ra; mem_ready = rdy;
    #1;
    sio = (sa & 16'hF000) == 16'hF000;
    tgt = -1;
    if (stv && !sio)
      for (int i = 1; i < q.size(); i++)
        if (!q[i].io && q[i].blk == sa[15:4]) tgt = i;
    efull = stv && (tgt < 0) && (q.size() == 4);
    chk("R7", "st_full", st_full, efull);
    chk("R3", "mem_valid", mem_valid, q.size() > 0);
    if (q.size() > 0) begin
      chk("R2", "mem_addr", mem_addr, {q[0].blk, 4'h0});
      chk(ptag, "mem_data", mem_data, q[0].data);
      chk(ptag, "mem_be", mem_be, q[0].mask);
    end
    rs = int'(ra[3:2]);
    y  = -1;
    for (int i = 0; i < q.size(); i++)
      if (q[i].blk == ra[15:4] && q[i].mask[rs*4 +: 4] != 4'h0) y = i;
    efwd  = rdv && (y >= 0) && (q[y].mask[rs*4 +: 4] == 4'hF);
    ewait = rdv && (y >= 0) && !efwd;
    edata = efwd ? q[y].data[rs*32 +: 32] : 32'h0;
    rtag  = (rovr != "") ? rovr : (!rdv || y < 0) ? "R8" : efwd ? "R9" : "R10";
    chk(rtag, "rd_fwd", rd_fwd, efwd);
    chk(rtag, "rd_wait", rd_wait, ewait);
    chk(rtag, "rd_data", rd_data, edata);
    dopop = (q.size() > 0) && rdy;
    ss = int'(sa[3:2]);
    if (tgt >= 0)
      for (int b = 0; b < 4; b++)
        if (sbe[b]) begin
          q[tgt].data[ss*32 + b*8 +: 8] = sd[b*8 +: 8];
          q[tgt].mask[ss*4 + b] = 1'b1;
        end
    if (dopop) void'(q.pop_front());
    if (stv && tgt < 0 && !efull) begin
      ent_t e;
      e.blk = sa[15:4]; e.data = '0; e.mask = '0; e.io = sio;
      for (int b = 0; b < 4; b++)
        if (sbe[b]) begin
          e.data[ss*32 + b*8 +: 8] = sd[b*8 +: 8];
          e.mask[ss*4 + b] = 1'b1;
        end
      q.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic idle(bit rdy);
    apply(0, 16'h0, 32'h0, 4'h0, 0, 16'h0, rdy);
  endtask

  task automatic rd(logic [15:0] ra);
    apply(0, 16'h0, 32'h0, 4'h0, 1, ra, 0);
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    rd_valid = 1; rd_addr = 16'h0124; mem_ready = 1;
    repeat (3) @(negedge clk);
    chk("R1", "mem_valid", mem_valid, 0);
    chk("R1", "st_full", st_full, 0);
    chk("R1", "rd_fwd", rd_fwd, 0);
    chk("R1", "rd_wait", rd_wait, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: first store allocates; R11 read of it in the same cycle sees nothing
    ptag = "R2"; rovr = "R11";
    apply(1, 16'h0124, 32'hA1B2C3D4, 4'hF, 1, 16'h0124, 0);
    rd(16'h0124);
    rovr = "";
    // R4: merge into a non-head entry
    ptag = "R4";
    apply(1, 16'h0200, 32'h11223344, 4'h3, 0, 0, 0);
    apply(1, 16'h0208, 32'h55667788, 4'hC, 0, 0, 0);
    apply(1, 16'h0200, 32'h99AABBCC, 4'h4, 0, 0, 0);
    // R5: block of the head entry takes a new entry
    ptag = "R5";
    apply(1, 16'h0120, 32'hDEADBEEF, 4'hF, 0, 0, 0);
    rd(16'h0200);
    rd(16'h0208);
    rd(16'h0124);
    rd(16'h0120);
    rd(16'h0500);
    // R7: fill, stall, merge while full, drain in the stall cycle
    ptag = "R7";
    apply(1, 16'h0300, 32'h01020304, 4'hF, 0, 0, 0);
    apply(1, 16'h0400, 32'hCAFEF00D, 4'hF, 0, 0, 0);
    apply(1, 16'h0400, 32'hCAFEF00D, 4'hF, 0, 0, 0);
    apply(1, 16'h0208, 32'h0BAD0BAD, 4'h3, 1, 16'h0208, 0);
    apply(1, 16'h0400, 32'hCAFEF00D, 4'hF, 0, 0, 1);
    apply(1, 16'h0400, 32'hCAFEF00D, 4'hF, 0, 0, 0);
    // R3: drain with a toggling ready
    ptag = "R3";
    for (int k = 0; k < 10; k++) idle(k[0]);
    // R6: I/O stores never merge
    ptag = "R6";
    apply(1, 16'hF010, 32'h00000001, 4'hF, 0, 0, 0);
    apply(1, 16'hF010, 32'h00000002, 4'hF, 0, 0, 0);
    apply(1, 16'hF014, 32'h00000003, 4'h1, 0, 0, 0);
    rd(16'hF010);
    rd(16'hF014);
    for (int k = 0; k < 6; k++) idle(1);
    // mixed traffic
    ptag = "R4";
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] blks [4];
      logic [15:0] a, r;
      blks[0] = 16'h0200; blks[1] = 16'h0210; blks[2] = 16'h0220; blks[3] = 16'hF010;
      a = blks[$urandom % 4] | 16'(($urandom % 4) * 4);
      r = blks[$urandom % 4] | 16'(($urandom % 4) * 4);
      apply(($urandom % 3) != 0, a, $urandom, 4'(($urandom % 15) + 1),
            ($urandom % 2) == 1, r, ($urandom % 3) == 0);
    end
    ptag = "R3";
    for (int k = 0; k < 6; k++) idle(1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule